// File: doc/BRIEF.md
# APM SMI Control Unit

This unit sits beside the power-management register file of a platform controller. Firmware and the operating system write one-byte commands to the APM command port. Two reserved command values switch ACPI mode: they set or clear the SCI-enable bit and never interrupt the processor. Every other value is a software trap. The trap raises a single-cycle SMI request when the APM-trap enable bit in the SMI enable register is set.

Two registers sit on a small register bus. The SMI enable register holds the global SMI enable, the APM-trap enable and general enable bits. The PM control register holds the SCI-enable bit and a write-once lock bit. After the lock is set, no bus write can clear it, and the global SMI enable bit no longer accepts bus writes. Only a reset releases the lock. A restore port loads both registers in one cycle, for example after saved state is brought back. The lock then follows the loaded value.

Top module: `pmc_smi_ctl`

## Requirements
- R1: After reset, the SMI enable register reads 0, the PM control register reads 0, `sci_en` is 0 and `smi_req` is 0.
- R2: An APM write of 0xF1 sets `sci_en`, which is PM control bit 0. It produces no SMI request, even when the trap enable is set.
- R3: An APM write of 0xF0 clears `sci_en`. It produces no SMI request.
- R4: An APM write of any other value, when bit 5 of the SMI enable register is 1, drives `smi_req` high for exactly the one cycle after the write. `sci_en` does not change.
- R5: An APM write of any other value, when bit 5 of the SMI enable register is 0, leaves `smi_req` low.
- R6: Address 0 is the SMI enable register. All of its bits can be written and read back while unlocked. Address 1 is the PM control register. In that register bit 0 is SCI enable and bit 4 is the lock, and all other bits read 0.
- R7: A bus write with bit 4 set at address 1 sets the lock. Later writes with bit 4 clear leave the lock set.
- R8: While the lock is set, bus writes leave bit 0 of the SMI enable register unchanged. All other bits of that register still take the written value.
- R9: A restore load replaces both registers, and it takes precedence over a bus write or an APM write in the same cycle. When the loaded PM control value has bit 4 set, R7 and R8 apply from the next cycle on.
- R10: An APM write of 0xF0 or 0xF1 in the same cycle as a bus write to address 1 decides `sci_en`. The bus write still decides the lock bit.
- R11: Addresses other than 0 and 1 read 0, and writes to them change no register.
- R12: Reset clears the lock. After reset, bit 0 of the SMI enable register accepts writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| apm_wr | input | 1 | APM command write strobe |
| apm_cmd | input | 8 | APM command byte |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | 2 | Register bus address |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Register bus read data, combinational from `reg_addr` |
| rs_load | input | 1 | Restore load strobe |
| rs_smi_en | input | 32 | Restored SMI enable register value |
| rs_pm_ctl | input | 16 | Restored PM control register value |
| smi_req | output | 1 | SMI request pulse |
| sci_en | output | 1 | ACPI SCI-enable status |

## Verification
The bench checks that the two ACPI command values never trap while the trap enable is set. A decoder that let them through would show an SMI pulse next to the change of `sci_en`. It then sets the lock, tries to clear the lock, and writes a pattern with bit 0 clear to the SMI enable register. A lock that was only checked on the setting write, or a mask on the wrong bit, would show as a changed read-back. It also writes an ACPI command and the PM control register in the same cycle, restores a locked state, and resets again to confirm that the lock is released. A design with the wrong priority, or one that did not re-apply the lock from restored state, would read back the wrong value.

// File: rtl/pmc_smi_pkg.sv
package pmc_smi_pkg;
  typedef enum logic [1:0] {
    APM_IDLE     = 2'd0,
    APM_ACPI_ON  = 2'd1,
    APM_ACPI_OFF = 2'd2,
    APM_TRAP     = 2'd3
  } apm_kind_t;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pmc_apm_decode.sv
module pmc_apm_decode
  import pmc_smi_pkg::*;
#(
  parameter int unsigned     CMD_W   = 8,
  parameter logic [CMD_W-1:0] ON_CMD  = 8'hF1,
  parameter logic [CMD_W-1:0] OFF_CMD = 8'hF0
) (
  input  logic             valid,
  input  logic [CMD_W-1:0] cmd,
  output apm_kind_t        kind
);
  always_comb begin
    if (!valid)              kind = APM_IDLE;
    else if (cmd == ON_CMD)  kind = APM_ACPI_ON;
    else if (cmd == OFF_CMD) kind = APM_ACPI_OFF;
    else                     kind = APM_TRAP;
  end
endmodule

// File: rtl/pmc_pm_ctl_reg.sv
module pmc_pm_ctl_reg
  import pmc_smi_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned SCI_BIT  = 0,
  parameter int unsigned LOCK_BIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  apm_kind_t    kind,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] q,
  output logic         lock,
  output logic         sci
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] KEEP = (ONE << SCI_BIT) | (ONE << LOCK_BIT);

  logic [W-1:0] d;
  logic         acpi_cmd;
  logic         upd;

  assign acpi_cmd = (kind == APM_ACPI_ON) || (kind == APM_ACPI_OFF);
  assign upd      = ld_en || wr_en || acpi_cmd;

  always_comb begin
    d = q;
    if (ld_en) begin
      d = ld_data & KEEP;
    end else begin
      if (wr_en) begin
        d = wdata & KEEP;
        if (q[LOCK_BIT]) d[LOCK_BIT] = 1'b1;
      end
      if (kind == APM_ACPI_ON)       d[SCI_BIT] = 1'b1;
      else if (kind == APM_ACPI_OFF) d[SCI_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  assign lock = q[LOCK_BIT];
  assign sci  = q[SCI_BIT];
endmodule

// File: rtl/pmc_smi_en_reg.sv
module pmc_smi_en_reg #(
  parameter int unsigned W       = 32,
  parameter int unsigned GBL_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         locked,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         upd;

  assign upd = ld_en || wr_en;

  always_comb begin
    if (ld_en) begin
      d = ld_data;
    end else begin
      d = wdata;
      if (locked) d[GBL_BIT] = q[GBL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/pmc_smi_pulse.sv
module pmc_smi_pulse
  import pmc_smi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  apm_kind_t kind,
  input  logic      trap_en,
  output logic      smi_req
);
  logic smi_d;

  assign smi_d = (kind == APM_TRAP) && trap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_req <= 1'b0;
    else        smi_req <= smi_d;
  end
endmodule

// File: rtl/pmc_smi_ctl.sv
module pmc_smi_ctl
  import pmc_smi_pkg::*;
#(
  parameter int unsigned      CMD_W    = 8,
  parameter logic [CMD_W-1:0] ON_CMD   = 8'hF1,
  parameter logic [CMD_W-1:0] OFF_CMD  = 8'hF0,
  parameter int unsigned      ADDR_W   = 2,
  parameter int unsigned      SMI_W    = 32,
  parameter int unsigned      PM_W     = 16,
  parameter int unsigned      TRAP_BIT = 5,
  parameter int unsigned      GBL_BIT  = 0,
  parameter int unsigned      SCI_BIT  = 0,
  parameter int unsigned      LOCK_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apm_wr,
  input  logic [CMD_W-1:0]  apm_cmd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [SMI_W-1:0]  reg_wdata,
  output logic [SMI_W-1:0]  reg_rdata,
  input  logic              rs_load,
  input  logic [SMI_W-1:0]  rs_smi_en,
  input  logic [PM_W-1:0]   rs_pm_ctl,
  output logic              smi_req,
  output logic              sci_en
);
  localparam logic [ADDR_W-1:0] ADDR_SMI = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PM  = ADDR_W'(1);
  localparam int unsigned       PAD_W    = SMI_W - PM_W;

  logic             srst_n;
  apm_kind_t        kind;
  logic             wr_smi;
  logic             wr_pm;
  logic [SMI_W-1:0] smi_en_q;
  logic [PM_W-1:0]  pm_q;
  logic             lock_q;

  assign wr_smi = reg_wr && (reg_addr == ADDR_SMI);
  assign wr_pm  = reg_wr && (reg_addr == ADDR_PM);

  pmc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pmc_apm_decode #(
    .CMD_W   (CMD_W),
    .ON_CMD  (ON_CMD),
    .OFF_CMD (OFF_CMD)
  ) u_dec (
    .valid (apm_wr),
    .cmd   (apm_cmd),
    .kind  (kind)
  );

  pmc_pm_ctl_reg #(
    .W        (PM_W),
    .SCI_BIT  (SCI_BIT),
    .LOCK_BIT (LOCK_BIT)
  ) u_pm (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_pm),
    .wdata   (reg_wdata[PM_W-1:0]),
    .kind    (kind),
    .ld_en   (rs_load),
    .ld_data (rs_pm_ctl),
    .q       (pm_q),
    .lock    (lock_q),
    .sci     (sci_en)
  );

  pmc_smi_en_reg #(
    .W       (SMI_W),
    .GBL_BIT (GBL_BIT)
  ) u_smi (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_smi),
    .wdata   (reg_wdata),
    .locked  (lock_q),
    .ld_en   (rs_load),
    .ld_data (rs_smi_en),
    .q       (smi_en_q)
  );

  pmc_smi_pulse u_pulse (
    .clk     (clk),
    .rst_n   (srst_n),
    .kind    (kind),
    .trap_en (smi_en_q[TRAP_BIT]),
    .smi_req (smi_req)
  );

  always_comb begin
    case (reg_addr)
      ADDR_SMI: reg_rdata = smi_en_q;
      ADDR_PM:  reg_rdata = {{PAD_W{1'b0}}, pm_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmc_smi_chk.sv
module pmc_smi_chk #(
  parameter int unsigned      CMD_W   = 8,
  parameter logic [CMD_W-1:0] ON_CMD  = 8'hF1,
  parameter logic [CMD_W-1:0] OFF_CMD = 8'hF0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             apm_wr,
  input logic [CMD_W-1:0] apm_cmd,
  input logic             rs_load,
  input logic             smi_req,
  input logic             sci_en,
  input logic             trap_en,
  input logic             gbl_en,
  input logic             lock
);
  logic is_acpi;
  assign is_acpi = (apm_cmd == ON_CMD) || (apm_cmd == OFF_CMD);

  assert_acpi_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_cmd == ON_CMD && !rs_load) |=> sci_en);

  assert_acpi_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_cmd == OFF_CMD && !rs_load) |=> !sci_en);

  assert_acpi_no_smi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && is_acpi) |=> !smi_req);

  assert_smi_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> ($past(apm_wr) && !$past(is_acpi) && $past(trap_en)));

  assert_trap_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !is_acpi && !trap_en) |=> !smi_req);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !rs_load) |=> lock);

  assert_gbl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !rs_load) |=> $stable(gbl_en));
endmodule

bind pmc_smi_ctl pmc_smi_chk #(
  .CMD_W   (CMD_W),
  .ON_CMD  (ON_CMD),
  .OFF_CMD (OFF_CMD)
) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .apm_wr  (apm_wr),
  .apm_cmd (apm_cmd),
  .rs_load (rs_load),
  .smi_req (smi_req),
  .sci_en  (sci_en),
  .trap_en (smi_en_q[TRAP_BIT]),
  .gbl_en  (smi_en_q[GBL_BIT]),
  .lock    (lock_q)
);

// File: tb/sim_pmc_smi_ctl.sv
module sim_pmc_smi_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        apm_wr;
  logic [7:0]  apm_cmd;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rs_load;
  logic [31:0] rs_smi_en;
  logic [15:0] rs_pm_ctl;
  logic        smi_req;
  logic        sci_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pmc_smi_ctl u0 (
    .clk(clk), .rst_n(rst_n), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rs_load(rs_load), .rs_smi_en(rs_smi_en),
    .rs_pm_ctl(rs_pm_ctl), .smi_req(smi_req), .sci_en(sci_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // one APM write; returns smi_req in the cycle after and the cycle after that
  task automatic apm(input logic [7:0] c, output logic p0, output logic p1);
    @(negedge clk);
    apm_wr = 1'b1; apm_cmd = c;
    @(negedge clk);
    apm_wr = 1'b0;
    p0 = smi_req;
    @(negedge clk);
    p1 = smi_req;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(2'd0, d); chk("R1", "smi enable after reset", d, 32'h0);
    rd(2'd1, d); chk("R1", "pm control after reset", d, 32'h0);
    chk("R1", "sci_en after reset", {31'b0, sci_en}, 32'h0);
    chk("R1", "smi_req after reset", {31'b0, smi_req}, 32'h0);
  endtask

  task automatic t_acpi();
    logic p0, p1;
    logic [31:0] d;
    wr(2'd0, 32'h0000_0020);
    apm(8'hF1, p0, p1);
    chk("R2", "sci_en after F1", {31'b0, sci_en}, 32'h1);
    chk("R2", "no smi on F1", {30'b0, p0, p1}, 32'h0);
    rd(2'd1, d); chk("R2", "pm control after F1", d, 32'h1);
    apm(8'hF0, p0, p1);
    chk("R3", "sci_en after F0", {31'b0, sci_en}, 32'h0);
    chk("R3", "no smi on F0", {30'b0, p0, p1}, 32'h0);
  endtask

  task automatic t_trap();
    logic p0, p1;
    apm(8'hB2, p0, p1);
    chk("R4", "smi pulse shape B2", {30'b0, p0, p1}, 32'h2);
    chk("R4", "sci_en unchanged on trap", {31'b0, sci_en}, 32'h0);
    apm(8'h00, p0, p1);
    chk("R4", "smi pulse shape 00", {30'b0, p0, p1}, 32'h2);
  endtask

  task automatic t_no_en();
    logic p0, p1;
    wr(2'd0, 32'hFFFF_FFDF);
    apm(8'h55, p0, p1);
    chk("R5", "no smi with trap enable clear", {30'b0, p0, p1}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'hA5A5_5A5A);
    rd(2'd0, d); chk("R6", "smi enable readback", d, 32'hA5A5_5A5A);
    wr(2'd1, 32'h0000_FFEF);
    rd(2'd1, d); chk("R6", "pm control masked readback", d, 32'h1);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R11", "unmapped reads zero", d, 32'h0);
    rd(2'd0, d); chk("R11", "smi enable untouched", d, 32'hA5A5_5A5A);
    rd(2'd1, d); chk("R11", "pm control untouched", d, 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
    apm_wr = 1'b1; apm_cmd = 8'hF0;
    @(negedge clk);
    reg_wr = 1'b0; apm_wr = 1'b0;
    chk("R10", "F0 beats bus write of sci", {31'b0, sci_en}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
    apm_wr = 1'b1; apm_cmd = 8'hF1;
    @(negedge clk);
    reg_wr = 1'b0; apm_wr = 1'b0;
    chk("R10", "F1 beats bus write of sci", {31'b0, sci_en}, 32'h1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    logic p0, p1;
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0000_0021);
    wr(2'd1, 32'h0000_0010);
    rd(2'd1, d); chk("R7", "lock set", d, 32'h10);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R7", "lock survives clear", d, 32'h10);
    wr(2'd0, 32'h0000_0F00);
    rd(2'd0, d); chk("R8", "global bit frozen, rest written", d, 32'h0000_0F01);
    apm(8'hF1, p0, p1);
    rd(2'd1, d); chk("R8", "acpi enable while locked", d, 32'h11);
  endtask

  task automatic t_reset_clear();
    logic [31:0] d;
    do_reset();
    rd(2'd1, d); chk("R12", "lock cleared by reset", d, 32'h0);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R12", "global bit writable again", d, 32'h1);
  endtask

  task automatic t_restore();
    logic [31:0] d;
    logic p0, p1;
    @(negedge clk);
    rs_load = 1'b1; rs_smi_en = 32'h0000_0020; rs_pm_ctl = 16'h0011;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    rs_load = 1'b0; reg_wr = 1'b0;
    rd(2'd0, d); chk("R9", "restored smi enable", d, 32'h20);
    rd(2'd1, d); chk("R9", "restored pm control", d, 32'h11);
    chk("R9", "restored sci_en", {31'b0, sci_en}, 32'h1);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R9", "restored lock freezes global bit", d, 32'h0);
    wr(2'd0, 32'h20);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R9", "restored lock sticky", d, 32'h10);
    apm(8'h77, p0, p1);
    chk("R9", "trap after restore", {30'b0, p0, p1}, 32'h2);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    rst_n = 1'b0; apm_wr = 1'b0; apm_cmd = '0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; rs_load = 1'b0; rs_smi_en = '0;
    rs_pm_ctl = '0;
    t_reset();
    t_acpi();
    t_trap();
    t_no_en();
    t_regs();
    t_collide();
    t_lock();
    t_reset_clear();
    t_restore();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule